// File: doc/BRIEF.md
# Four-Phase Level-Signalled Transfer Link

This block moves one data word from a requesting side to a serving side and brings a result word back, with two free-running clocks that share no timing relation. The two sides talk over a request line, an acknowledge line and two data buses. All meaning is in the levels of the lines: the requester raises its line and holds the word still, the server works and raises its answer line with the result held still, the requester takes the result and drops its line, and the server then drops its own. Only after this full return to zero may another word start.

On the requesting side a valid/ready pair accepts a word. The serving side stands in for a real server with a latency counter and a fixed operation on the word (increment or complement, picked by a parameter). Each line that crosses between the clocks goes through a synchroniser chain on the receiving side. A completed-transfer counter on the requesting side is there for checking. The link lines are also brought out as ports so the protocol can be observed.

Top module: `rz_link`

## Requirements
- R1: While either reset is held low and just after its release: `link_req`, `link_ack`, `out_valid` and `done_count` are 0, and `in_ready` is 1.
- R2: A word is taken only in a cycle where `in_valid` and `in_ready` are both 1. `in_ready` is 0 from the cycle after acceptance until the transfer has fully ended. With `in_valid` low, `link_req` stays low.
- R3: `link_ack` rises only while `link_req` is high.
- R4: For each accepted word D, `out_valid` pulses for exactly one master cycle, with `out_data` equal to the service result. With the default `SERVICE_OP` = 0 this is D+1 modulo 2^W. With `SERVICE_OP` = 1 it is the bitwise complement of D.
- R5: `link_rsp_data` does not change while `link_ack` stays high.
- R6: `link_req` falls only while `link_ack` is high.
- R7: `link_ack` falls only while `link_req` is low.
- R8: `link_req` rises only while `link_ack` is low. When `in_ready` returns to 1 after a transfer, both link lines are low.
- R9: `done_count` grows by exactly one for each completed four-step transfer, modulo 2^CNT_W.
- R10: `link_fwd_data` equals the accepted word and does not change while `link_req` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_m | input | 1 | Requesting-side clock |
| rst_m_n | input | 1 | Requesting-side asynchronous reset, active low |
| clk_s | input | 1 | Serving-side clock |
| rst_s_n | input | 1 | Serving-side asynchronous reset, active low |
| in_valid | input | 1 | A word is offered |
| in_ready | output | 1 | The link can take a word |
| in_data | input | W | Offered word |
| out_valid | output | 1 | One-cycle pulse: result available |
| out_data | output | W | Result word |
| done_count | output | CNT_W | Completed transfers |
| link_req | output | 1 | Request line level |
| link_ack | output | 1 | Acknowledge line level |
| link_fwd_data | output | W | Word carried toward the server |
| link_rsp_data | output | W | Result carried back from the server |

## Verification
The ordering rules of the four steps are checked on every edge of the clock that samples each line: request and acknowledge may only change while the other line is at the level the protocol requires, and both data buses hold still while their line is high. The value of each result, the one-shot nature of `out_valid`, the refusal of new words during a transfer, and the counter's growth can only be shown by the bench. Its scenarios run many transfers with random words and gaps, plus the words zero and all ones (wrap) and long idle stretches with no word offered.

// File: rtl/rz_pkg.sv
package rz_pkg;

   typedef enum logic [1:0] {
      M_IDLE         = 2'd0,
      M_REQ          = 2'd1,
      M_WAIT_ACK_LOW = 2'd2
   } mst_state_t;

   typedef enum logic [1:0] {
      S_IDLE = 2'd0,
      S_BUSY = 2'd1,
      S_ACK  = 2'd2
   } slv_state_t;

endpackage

// File: rtl/rz_sync.sv
module rz_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d,
   output logic q
);
   generate
      if (STAGES < 2) begin : g_bad_stages
         $error("rz_sync: STAGES must be at least 2");
      end
   endgenerate

   logic [STAGES-1:0] chain;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain <= '0;
      else        chain <= {chain[STAGES-2:0], d};
   end

   assign q = chain[STAGES-1];
endmodule

// File: rtl/rz_master.sv
module rz_master
   import rz_pkg::*;
#(
   parameter int W      = 8,
   parameter int CNT_W  = 16,
   parameter int SYNC_N = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             in_valid,
   output logic             in_ready,
   input  logic [W-1:0]     in_data,
   output logic             out_valid,
   output logic [W-1:0]     out_data,
   output logic [CNT_W-1:0] done_count,
   output logic             req,
   output logic [W-1:0]     fwd_data,
   input  logic             ack_async,
   input  logic [W-1:0]     rsp_async
);
   mst_state_t state;
   logic       ack_s;

   rz_sync #(.STAGES(SYNC_N)) u_ack_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d     (ack_async),
      .q     (ack_s)
   );

   assign in_ready = (state == M_IDLE) && !ack_s;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state      <= M_IDLE;
         req        <= 1'b0;
         fwd_data   <= '0;
         out_valid  <= 1'b0;
         out_data   <= '0;
         done_count <= '0;
      end else begin
         out_valid <= 1'b0;
         case (state)
            M_IDLE: begin
               if (in_valid && in_ready) begin
                  fwd_data <= in_data;
                  req      <= 1'b1;
                  state    <= M_REQ;
               end
            end
            M_REQ: begin
               if (ack_s) begin
                  out_data  <= rsp_async;
                  out_valid <= 1'b1;
                  req       <= 1'b0;
                  state     <= M_WAIT_ACK_LOW;
               end
            end
            M_WAIT_ACK_LOW: begin
               if (!ack_s) begin
                  done_count <= done_count + CNT_W'(1);
                  state      <= M_IDLE;
               end
            end
            default: state <= M_IDLE;
         endcase
      end
   end
endmodule

// File: rtl/rz_slave.sv
module rz_slave
   import rz_pkg::*;
#(
   parameter int W          = 8,
   parameter int LATENCY    = 3,
   parameter int SERVICE_OP = 0,
   parameter int SYNC_N     = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         req_async,
   input  logic [W-1:0] fwd_async,
   output logic         ack,
   output logic [W-1:0] rsp_data
);
   localparam int LW = (LATENCY < 2) ? 1 : $clog2(LATENCY);

   generate
      if (LATENCY < 1) begin : g_bad_latency
         $error("rz_slave: LATENCY must be at least 1");
      end
      if (SERVICE_OP != 0 && SERVICE_OP != 1) begin : g_bad_op
         $error("rz_slave: SERVICE_OP must be 0 or 1");
      end
   endgenerate

   slv_state_t    state;
   logic          req_s;
   logic [LW-1:0] wait_cnt;
   logic [W-1:0]  held;
   logic [W-1:0]  result;

   rz_sync #(.STAGES(SYNC_N)) u_req_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d     (req_async),
      .q     (req_s)
   );

   generate
      if (SERVICE_OP == 0) begin : g_incr
         assign result = held + W'(1);
      end else begin : g_invert
         assign result = ~held;
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state    <= S_IDLE;
         ack      <= 1'b0;
         rsp_data <= '0;
         held     <= '0;
         wait_cnt <= '0;
      end else begin
         case (state)
            S_IDLE: begin
               if (req_s) begin
                  held     <= fwd_async;
                  wait_cnt <= LW'(LATENCY - 1);
                  state    <= S_BUSY;
               end
            end
            S_BUSY: begin
               if (wait_cnt == '0) begin
                  rsp_data <= result;
                  ack      <= 1'b1;
                  state    <= S_ACK;
               end else begin
                  wait_cnt <= wait_cnt - LW'(1);
               end
            end
            S_ACK: begin
               if (!req_s) begin
                  ack   <= 1'b0;
                  state <= S_IDLE;
               end
            end
            default: state <= S_IDLE;
         endcase
      end
   end
endmodule

// File: rtl/rz_link.sv
module rz_link #(
   parameter int W          = 8,
   parameter int CNT_W      = 16,
   parameter int LATENCY    = 3,
   parameter int SERVICE_OP = 0,
   parameter int SYNC_N     = 2
) (
   input  logic             clk_m,
   input  logic             rst_m_n,
   input  logic             clk_s,
   input  logic             rst_s_n,
   input  logic             in_valid,
   output logic             in_ready,
   input  logic [W-1:0]     in_data,
   output logic             out_valid,
   output logic [W-1:0]     out_data,
   output logic [CNT_W-1:0] done_count,
   output logic             link_req,
   output logic             link_ack,
   output logic [W-1:0]     link_fwd_data,
   output logic [W-1:0]     link_rsp_data
);
   generate
      if (W < 1 || CNT_W < 1) begin : g_bad_width
         $error("rz_link: W and CNT_W must be positive");
      end
   endgenerate

   rz_master #(.W(W), .CNT_W(CNT_W), .SYNC_N(SYNC_N)) u_mst (
      .clk        (clk_m),
      .rst_n      (rst_m_n),
      .in_valid   (in_valid),
      .in_ready   (in_ready),
      .in_data    (in_data),
      .out_valid  (out_valid),
      .out_data   (out_data),
      .done_count (done_count),
      .req        (link_req),
      .fwd_data   (link_fwd_data),
      .ack_async  (link_ack),
      .rsp_async  (link_rsp_data)
   );

   rz_slave #(.W(W), .LATENCY(LATENCY), .SERVICE_OP(SERVICE_OP), .SYNC_N(SYNC_N)) u_slv (
      .clk       (clk_s),
      .rst_n     (rst_s_n),
      .req_async (link_req),
      .fwd_async (link_fwd_data),
      .ack       (link_ack),
      .rsp_data  (link_rsp_data)
   );
endmodule

// File: rtl/rz_link_chk.sv
module rz_link_chk #(
   parameter int W = 8
) (
   input logic         clk_m,
   input logic         rst_m_n,
   input logic         clk_s,
   input logic         rst_s_n,
   input logic         link_req,
   input logic         link_ack,
   input logic [W-1:0] link_fwd_data,
   input logic [W-1:0] link_rsp_data,
   input logic         in_ready
);
   // R3
   ack_needs_req_chk: assert property (@(posedge clk_s) disable iff (!rst_s_n || !rst_m_n)
      $rose(link_ack) |-> link_req);

   // R5
   rsp_stable_chk: assert property (@(posedge clk_s) disable iff (!rst_s_n || !rst_m_n)
      (link_ack && $past(link_ack)) |-> $stable(link_rsp_data));

   // R6
   req_drop_chk: assert property (@(posedge clk_m) disable iff (!rst_m_n || !rst_s_n)
      $fell(link_req) |-> link_ack);

   // R7
   ack_drop_chk: assert property (@(posedge clk_s) disable iff (!rst_s_n || !rst_m_n)
      $fell(link_ack) |-> !link_req);

   // R8
   req_rise_chk: assert property (@(posedge clk_m) disable iff (!rst_m_n || !rst_s_n)
      $rose(link_req) |-> !link_ack);

   // R10
   fwd_stable_chk: assert property (@(posedge clk_m) disable iff (!rst_m_n || !rst_s_n)
      (link_req && $past(link_req)) |-> $stable(link_fwd_data));

   // R2
   busy_not_ready_chk: assert property (@(posedge clk_m) disable iff (!rst_m_n || !rst_s_n)
      link_req |-> !in_ready);
endmodule

bind rz_link rz_link_chk #(.W(W)) u_chk (
   .clk_m         (clk_m),
   .rst_m_n       (rst_m_n),
   .clk_s         (clk_s),
   .rst_s_n       (rst_s_n),
   .link_req      (link_req),
   .link_ack      (link_ack),
   .link_fwd_data (link_fwd_data),
   .link_rsp_data (link_rsp_data),
   .in_ready      (in_ready)
);

// File: tb/sim_rz_link.sv
`timescale 1ns/1ps
module sim_rz_link;
   localparam int W     = 8;
   localparam int CNT_W = 16;

   logic             clk_m = 1'b0;
   logic             clk_s = 1'b0;
   logic             rst_m_n = 1'b0;
   logic             rst_s_n = 1'b0;
   logic             in_valid = 1'b0;
   logic [W-1:0]     in_data = '0;
   logic             in_ready;
   logic             out_valid;
   logic [W-1:0]     out_data;
   logic [CNT_W-1:0] done_count;
   logic             link_req;
   logic             link_ack;
   logic [W-1:0]     link_fwd_data;
   logic [W-1:0]     link_rsp_data;

   int checks = 0;
   int errors = 0;
   int exp_count = 0;
   int cycles = 0;

   rz_link #(.W(W), .CNT_W(CNT_W), .LATENCY(3), .SERVICE_OP(0), .SYNC_N(2)) u0 (
      .clk_m, .rst_m_n, .clk_s, .rst_s_n,
      .in_valid, .in_ready, .in_data,
      .out_valid, .out_data, .done_count,
      .link_req, .link_ack, .link_fwd_data, .link_rsp_data
   );

   always #5 clk_m = ~clk_m;
   initial begin
      #3;
      forever #7 clk_s = ~clk_s;
   end

   function automatic logic [W-1:0] svc(input logic [W-1:0] d);
      return d + W'(1);
   endfunction

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic finish_run();
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   endtask

   always @(posedge clk_m) begin
      cycles++;
      if (cycles > 150000) begin
         checks++;
         errors++;
         $display("FAIL watchdog actual=%0d expected=<150000", cycles);
         finish_run();
      end
   end

   task automatic xfer(input logic [W-1:0] d);
      int pulses;
      @(negedge clk_m);
      while (!in_ready) @(negedge clk_m);
      in_valid = 1'b1;
      in_data  = d;
      @(negedge clk_m);
      in_valid = 1'b0;
      in_data  = $urandom;
      // R2: busy after acceptance
      chk("R2 ready low after accept", {31'd0, in_ready}, 32'd0);
      while (!out_valid) @(negedge clk_m);
      // R4
      chk("R4 result", {24'd0, out_data}, {24'd0, svc(d)});
      // R10
      chk("R10 forward word", {24'd0, link_fwd_data}, {24'd0, d});
      // R6: ack seen high when result taken
      chk("R6 ack high at capture", {31'd0, link_ack}, 32'd1);
      pulses = 1;
      while (!in_ready) begin
         @(negedge clk_m);
         if (out_valid) pulses++;
      end
      chk("R4 single pulse", pulses, 32'd1);
      exp_count = (exp_count + 1) % (1 << CNT_W);
      // R9
      chk("R9 done count", {16'd0, done_count}, exp_count);
      // R8
      chk("R8 lines low at ready", {30'd0, link_req, link_ack}, 32'd0);
   endtask

   initial begin
      void'($urandom(32'd1234));
      #1;
      // R1: during reset
      chk("R1 req in reset", {31'd0, link_req}, 32'd0);
      chk("R1 ack in reset", {31'd0, link_ack}, 32'd0);
      repeat (4) @(negedge clk_m);
      rst_m_n = 1'b1;
      rst_s_n = 1'b1;
      @(negedge clk_m);
      chk("R1 ready", {31'd0, in_ready}, 32'd1);
      chk("R1 out_valid", {31'd0, out_valid}, 32'd0);
      chk("R1 count", {16'd0, done_count}, 32'd0);

      // R2: nothing offered, nothing sent
      repeat (25) begin
         @(negedge clk_m);
         chk("R2 idle no request", {31'd0, link_req}, 32'd0);
      end

      xfer(8'h00);
      xfer(8'hFF);
      xfer(8'h7F);
      xfer(8'hFF);

      for (int i = 0; i < 40; i++) begin
         int gap;
         gap = $urandom_range(0, 5);
         repeat (gap) @(negedge clk_m);
         xfer(W'($urandom));
      end

      // R9: idle stretch leaves count unchanged
      repeat (30) @(negedge clk_m);
      chk("R9 count after idle", {16'd0, done_count}, exp_count);
      finish_run();
   end
endmodule